// File: doc/BRIEF.md
# Processor Exception Entry Controller

This block sits beside the pipeline of a 32-bit processor. It decides which exception vector the core must enter when a fault or a debug event is raised, and it holds the registers that record the entry. It keeps the processor status word, an array of saved-PC registers (one per interrupt level), an array of saved-status registers, a dedicated double-fault PC register, a cause register, a fault-address register and a debug-cause register. Every register update commits on the same clock edge that presents the vector selection. The selection is held for exactly one cycle.

A fault raised while the status word already shows exception mode is a nested fault. It takes the double vector and does not overwrite the level-1 saved PC when the double-fault PC register is built in. A debug request is accepted only below the configured debug level. When accepted, it saves state into the slots for that level and raises the interrupt level to it. A misaligned-access strobe becomes an alignment fault only when the build enables unaligned-access exceptions and does not handle misalignment in hardware.

The controller is one state machine whose state names the entry just taken. The states are ST_QUIET (no entry this cycle), ST_KERNEL, ST_USER, ST_DOUBLE and ST_DEBUG. Every state can move to every other state on each clock, under this priority:
- an accepted debug request goes to ST_DEBUG;
- otherwise any fault goes to ST_DOUBLE if exception mode is set;
- otherwise to ST_USER if the user bit is set;
- otherwise to ST_KERNEL;
- with no request, the machine goes to ST_QUIET.

Top module: `exc_entry_ctrl`

## Requirements
- R1: A fault (fault request or enabled misalignment) raised while the exception-mode bit (status bit LVL_W+1, bit 4 by default) is set enters the double vector, `vec_sel` = 2.
- R2: On a double entry the PC goes to `dbl_pc` when HAS_DEPC = 1, and the level-1 saved PC is left unchanged. When HAS_DEPC = 0 the PC goes to the level-1 saved PC and `dbl_pc` reads zero.
- R3: On a non-nested fault the PC goes to the level-1 saved PC, which is slot 0, bits 31:0 of `saved_pc`. The vector is user (`vec_sel` = 1) when the user bit (status bit LVL_W, bit 3 by default) is set, and kernel (`vec_sel` = 0) otherwise.
- R4: Every non-debug entry writes the cause register and sets the exception-mode bit. All other status bits are kept.
- R5: The fault-address register loads `exc_vaddr` on a fault request with `exc_addr_vld` = 1, and on an alignment fault. On any other cycle it keeps its value.
- R6: A debug request is accepted only when `cur_level` < DEBUG_LEVEL. A rejected request has no effect, and any fault raised in the same cycle is handled as if the debug request were absent.
- R7: On debug entry `vec_sel` = 3. The PC is saved to slot DEBUG_LEVEL−1 of `saved_pc`, and the old status word to slot DEBUG_LEVEL−1 of `saved_sw` (slot k−1 holds level k; slot 0 of `saved_sw` always reads zero). `dbg_cause` loads `dbg_cause_in`. The level field (status bits LVL_W−1:0) becomes DEBUG_LEVEL, exception mode is set, and the user bit is kept.
- R8: A misalignment strobe raises cause 9 only when UNALIGNED_EXC = 1 and HW_ALIGN = 0. In any other build it is ignored.
- R9: Priority is accepted debug, then fault request, then misalignment. When a fault request and a misalignment strobe coincide, the cause is `exc_cause`.
- R10: A request sampled on a clock edge shows on `vec_valid`/`vec_sel` and on every register output right after that same edge. `vec_valid` is high for one cycle per entry, and `vec_sel` reads 0 while `vec_valid` is low.
- R11: After reset the status word has exception mode set, the user bit clear and the level field at its maximum (7 by default). Every other register reads zero and `vec_valid` is low.
- R12: `sw_wr` loads `sw_wdata` into the status word only on a cycle with no entry. On an entry cycle the write is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| exc_req | input | 1 | Fault request strobe |
| exc_cause | input | 6 | Cause code of the fault |
| exc_pc | input | 32 | PC of the faulting or debugged instruction |
| exc_addr_vld | input | 1 | Fault carries a virtual address |
| exc_vaddr | input | 32 | Faulting virtual address |
| misalign_req | input | 1 | Misaligned load/store detected |
| dbg_req | input | 1 | Debug event request |
| dbg_cause_in | input | 6 | Debug event cause |
| cur_level | input | LVL_W | Current interrupt level |
| sw_wr | input | 1 | Status-word write strobe |
| sw_wdata | input | LVL_W+2 | Status-word write value |
| vec_valid | output | 1 | Entry taken (one cycle) |
| vec_sel | output | 2 | 0 kernel, 1 user, 2 double, 3 debug |
| status | output | LVL_W+2 | Status word |
| saved_pc | output | 32·(2^LVL_W−1) | Saved PC per level, slot k−1 = level k |
| saved_sw | output | (LVL_W+2)·(2^LVL_W−1) | Saved status per level, slot k−1 = level k |
| dbl_pc | output | 32 | Double-fault PC |
| cause | output | 6 | Fault cause register |
| fault_vaddr | output | 32 | Fault virtual-address register |
| dbg_cause | output | 6 | Debug cause register |

## Verification
The bench builds two copies side by side from the same stimulus.

The first uses the defaults: three-bit level, debug level 6, a double-fault PC register, and the alignment gate open. In this copy nested faults land in `dbl_pc`, and misalignment raises cause 9.

The second has no double-fault PC register and handles misalignment in hardware. This brings within reach the fallback of nested faults into the level-1 slot and the ignored misalignment strobe.

With seven levels and the debug level at 6, random `cur_level` values fall both below and at or above the debug threshold.

// File: rtl/exc_pkg.sv
package exc_pkg;

    localparam int PC_W    = 32;
    localparam int CAUSE_W = 6;

    localparam logic [CAUSE_W-1:0] ALIGN_CAUSE = 6'd9;

    localparam logic [1:0] VEC_KERNEL = 2'd0;
    localparam logic [1:0] VEC_USER   = 2'd1;
    localparam logic [1:0] VEC_DOUBLE = 2'd2;
    localparam logic [1:0] VEC_DEBUG  = 2'd3;

    typedef enum logic [2:0] {
        ST_QUIET  = 3'd0,
        ST_KERNEL = 3'd1,
        ST_USER   = 3'd2,
        ST_DOUBLE = 3'd3,
        ST_DEBUG  = 3'd4
    } entry_state_e;

endpackage

// File: rtl/exc_align_gate.sv
module exc_align_gate #(
    parameter bit UNALIGNED_EXC = 1'b1,
    parameter bit HW_ALIGN      = 1'b0
) (
    input  logic misalign_req,
    output logic align_fault
);
    localparam bit GATE_OPEN = UNALIGNED_EXC && !HW_ALIGN;

    generate
        if (GATE_OPEN) begin : g_open
            assign align_fault = misalign_req;
        end else begin : g_closed
            logic unused_req;
            assign unused_req  = misalign_req;
            assign align_fault = 1'b0;
        end
    endgenerate
endmodule

// File: rtl/exc_classify.sv
module exc_classify
    import exc_pkg::*;
#(
    parameter int LVL_W       = 3,
    parameter int DEBUG_LEVEL = 6
) (
    input  logic             exc_req,
    input  logic             align_fault,
    input  logic             dbg_req,
    input  logic [LVL_W-1:0] cur_level,
    input  logic             user_bit,
    input  logic             excm_bit,
    output entry_state_e     state_nxt,
    output logic             dbg_ok
);
    localparam logic [LVL_W-1:0] DBG_L = LVL_W'(DEBUG_LEVEL);

    logic fault;

    always_comb begin
        dbg_ok = dbg_req && (cur_level < DBG_L);
        fault  = exc_req || align_fault;
        if (dbg_ok) begin
            state_nxt = ST_DEBUG;
        end else if (fault) begin
            if (excm_bit) begin
                state_nxt = ST_DOUBLE;
            end else if (user_bit) begin
                state_nxt = ST_USER;
            end else begin
                state_nxt = ST_KERNEL;
            end
        end else begin
            state_nxt = ST_QUIET;
        end
    end
endmodule

// File: rtl/exc_save_bank.sv
module exc_save_bank
    import exc_pkg::*;
#(
    parameter int LVL_W       = 3,
    parameter int DEBUG_LEVEL = 6,
    parameter bit HAS_DEPC    = 1'b1,
    localparam int MAX_LEVEL  = (1 << LVL_W) - 1,
    localparam int SW         = LVL_W + 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  entry_state_e            state_nxt,
    input  logic [PC_W-1:0]         pc,
    input  logic [SW-1:0]           sw_cur,
    output logic [MAX_LEVEL*PC_W-1:0] saved_pc,
    output logic [MAX_LEVEL*SW-1:0]   saved_sw,
    output logic [PC_W-1:0]         dbl_pc
);
    logic l1_take;
    logic dbg_take;

    always_comb begin
        unique case (state_nxt)
            ST_KERNEL, ST_USER: l1_take = 1'b1;
            ST_DOUBLE:          l1_take = !HAS_DEPC;
            default:            l1_take = 1'b0;
        endcase
        dbg_take = (state_nxt == ST_DEBUG);
    end

    generate
        for (genvar k = 1; k <= MAX_LEVEL; k++) begin : g_lvl
            localparam bit IS_L1  = (k == 1);
            localparam bit IS_DBG = (k == DEBUG_LEVEL);
            logic [PC_W-1:0] pc_q;
            logic [SW-1:0]   sw_q;
            logic            pc_we;
            logic            sw_we;

            assign pc_we = (IS_L1 && l1_take) || (IS_DBG && dbg_take);
            assign sw_we = IS_DBG && (k >= 2) && dbg_take;

            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    pc_q <= '0;
                    sw_q <= '0;
                end else begin
                    if (pc_we) pc_q <= pc;
                    if (sw_we) sw_q <= sw_cur;
                end
            end

            assign saved_pc[k*PC_W-1 -: PC_W] = pc_q;
            assign saved_sw[k*SW-1 -: SW]     = sw_q;

            if (IS_L1 && HAS_DEPC) begin : g_l1_chk
                assert_l1_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
                    (state_nxt == ST_DOUBLE) |=> $stable(pc_q));
            end
            if (IS_DBG) begin : g_dbg_chk
                assert_dbg_save_R7: assert property (@(posedge clk) disable iff (!rst_n)
                    (state_nxt == ST_DEBUG) |=> (pc_q == $past(pc)) && (sw_q == $past(sw_cur)));
            end
        end
    endgenerate

    generate
        if (HAS_DEPC) begin : g_depc
            logic [PC_W-1:0] dpc_q;
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    dpc_q <= '0;
                end else if (state_nxt == ST_DOUBLE) begin
                    dpc_q <= pc;
                end
            end
            assign dbl_pc = dpc_q;
        end else begin : g_no_depc
            assign dbl_pc = '0;
        end
    endgenerate
endmodule

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl
    import exc_pkg::*;
#(
    parameter int LVL_W         = 3,
    parameter int DEBUG_LEVEL   = 6,
    parameter bit HAS_DEPC      = 1'b1,
    parameter bit UNALIGNED_EXC = 1'b1,
    parameter bit HW_ALIGN      = 1'b0,
    localparam int MAX_LEVEL    = (1 << LVL_W) - 1,
    localparam int SW           = LVL_W + 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      exc_req,
    input  logic [5:0]                exc_cause,
    input  logic [31:0]               exc_pc,
    input  logic                      exc_addr_vld,
    input  logic [31:0]               exc_vaddr,
    input  logic                      misalign_req,
    input  logic                      dbg_req,
    input  logic [5:0]                dbg_cause_in,
    input  logic [LVL_W-1:0]          cur_level,
    input  logic                      sw_wr,
    input  logic [SW-1:0]             sw_wdata,
    output logic                      vec_valid,
    output logic [1:0]                vec_sel,
    output logic [SW-1:0]             status,
    output logic [MAX_LEVEL*32-1:0]   saved_pc,
    output logic [MAX_LEVEL*SW-1:0]   saved_sw,
    output logic [31:0]               dbl_pc,
    output logic [5:0]                cause,
    output logic [31:0]               fault_vaddr,
    output logic [5:0]                dbg_cause
);
    localparam int UM_BIT   = LVL_W;
    localparam int EXCM_BIT = LVL_W + 1;
    localparam logic [LVL_W-1:0] DBG_L   = LVL_W'(DEBUG_LEVEL);
    localparam logic [LVL_W-1:0] LVL_MAX = LVL_W'(MAX_LEVEL);
    localparam logic [SW-1:0] SW_RESET   = {1'b1, 1'b0, LVL_MAX};

    entry_state_e state_q, state_nxt;
    logic         align_fault;
    logic         dbg_ok;
    logic [SW-1:0] sw_q, sw_nxt;
    logic [CAUSE_W-1:0] cause_q, dcause_q;
    logic [PC_W-1:0]    va_q;
    logic         fault_entry;
    logic         va_we;

    exc_align_gate #(
        .UNALIGNED_EXC (UNALIGNED_EXC),
        .HW_ALIGN      (HW_ALIGN)
    ) u_gate (
        .misalign_req (misalign_req),
        .align_fault  (align_fault)
    );

    exc_classify #(
        .LVL_W       (LVL_W),
        .DEBUG_LEVEL (DEBUG_LEVEL)
    ) u_classify (
        .exc_req     (exc_req),
        .align_fault (align_fault),
        .dbg_req     (dbg_req),
        .cur_level   (cur_level),
        .user_bit    (sw_q[UM_BIT]),
        .excm_bit    (sw_q[EXCM_BIT]),
        .state_nxt   (state_nxt),
        .dbg_ok      (dbg_ok)
    );

    exc_save_bank #(
        .LVL_W       (LVL_W),
        .DEBUG_LEVEL (DEBUG_LEVEL),
        .HAS_DEPC    (HAS_DEPC)
    ) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .state_nxt (state_nxt),
        .pc        (exc_pc),
        .sw_cur    (sw_q),
        .saved_pc  (saved_pc),
        .saved_sw  (saved_sw),
        .dbl_pc    (dbl_pc)
    );

    // Next status word and write enables for the cause and address registers.
    always_comb begin
        sw_nxt      = sw_q;
        fault_entry = 1'b0;
        unique case (state_nxt)
            ST_DEBUG: begin
                sw_nxt = {1'b1, sw_q[UM_BIT], DBG_L};
            end
            ST_KERNEL, ST_USER, ST_DOUBLE: begin
                sw_nxt[EXCM_BIT] = 1'b1;
                fault_entry      = 1'b1;
            end
            default: begin
                if (sw_wr) sw_nxt = sw_wdata;
            end
        endcase
        va_we = fault_entry && (exc_req ? exc_addr_vld : 1'b1);
    end

    // State register and record registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_QUIET;
            sw_q     <= SW_RESET;
            cause_q  <= '0;
            dcause_q <= '0;
            va_q     <= '0;
        end else begin
            state_q <= state_nxt;
            sw_q    <= sw_nxt;
            if (fault_entry) cause_q <= exc_req ? exc_cause : ALIGN_CAUSE;
            if (va_we) va_q <= exc_vaddr;
            if (state_nxt == ST_DEBUG) dcause_q <= dbg_cause_in;
        end
    end

    // Outputs decoded from the state.
    always_comb begin
        unique case (state_q)
            ST_KERNEL: begin vec_valid = 1'b1; vec_sel = VEC_KERNEL; end
            ST_USER:   begin vec_valid = 1'b1; vec_sel = VEC_USER;   end
            ST_DOUBLE: begin vec_valid = 1'b1; vec_sel = VEC_DOUBLE; end
            ST_DEBUG:  begin vec_valid = 1'b1; vec_sel = VEC_DEBUG;  end
            default:   begin vec_valid = 1'b0; vec_sel = VEC_KERNEL; end
        endcase
    end

    assign status      = sw_q;
    assign cause       = cause_q;
    assign fault_vaddr = va_q;
    assign dbg_cause   = dcause_q;

    assert_double_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_valid && vec_sel == VEC_DOUBLE) |-> $past(status[EXCM_BIT]));
    assert_user_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_valid && vec_sel == VEC_USER) |-> $past(status[UM_BIT]));
    assert_excm_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid |-> status[EXCM_BIT]);
    assert_dbg_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_valid && vec_sel == VEC_DEBUG) |-> ($past(cur_level) < DBG_L));
    assert_dbg_level_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_valid && vec_sel == VEC_DEBUG) |-> (status[LVL_W-1:0] == DBG_L));
    assert_dbg_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (dbg_req && cur_level < DBG_L) |=> (vec_valid && vec_sel == VEC_DEBUG));
    assert_quiet_sel_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !vec_valid |-> (vec_sel == VEC_KERNEL));
endmodule

// File: tb/exc_entry_ctrl_bench.sv
module exc_entry_ctrl_bench;
    localparam int LW   = 3;
    localparam int MAXL = 7;
    localparam int DBG  = 6;
    localparam int SW   = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic exc_req = 0, exc_addr_vld = 0, misalign_req = 0, dbg_req = 0, sw_wr = 0;
    logic [5:0]  exc_cause = 0, dbg_cause_in = 0;
    logic [31:0] exc_pc = 0, exc_vaddr = 0;
    logic [LW-1:0] cur_level = 0;
    logic [SW-1:0] sw_wdata = 0;

    logic a_v, b_v;
    logic [1:0] a_sel, b_sel;
    logic [SW-1:0] a_sw, b_sw;
    logic [MAXL*32-1:0] a_spc, b_spc;
    logic [MAXL*SW-1:0] a_ssw, b_ssw;
    logic [31:0] a_dpc, b_dpc, a_va, b_va;
    logic [5:0] a_c, b_c, a_dc, b_dc;

    int n_tests = 0;
    int n_fail  = 0;

    always #5 clk = ~clk;

    exc_entry_ctrl u_exc_entry_ctrl (
        .clk(clk), .rst_n(rst_n), .exc_req(exc_req), .exc_cause(exc_cause),
        .exc_pc(exc_pc), .exc_addr_vld(exc_addr_vld), .exc_vaddr(exc_vaddr),
        .misalign_req(misalign_req), .dbg_req(dbg_req), .dbg_cause_in(dbg_cause_in),
        .cur_level(cur_level), .sw_wr(sw_wr), .sw_wdata(sw_wdata),
        .vec_valid(a_v), .vec_sel(a_sel), .status(a_sw), .saved_pc(a_spc),
        .saved_sw(a_ssw), .dbl_pc(a_dpc), .cause(a_c), .fault_vaddr(a_va),
        .dbg_cause(a_dc));

    exc_entry_ctrl #(.HAS_DEPC(1'b0), .HW_ALIGN(1'b1)) u_exc_entry_ctrl_alt (
        .clk(clk), .rst_n(rst_n), .exc_req(exc_req), .exc_cause(exc_cause),
        .exc_pc(exc_pc), .exc_addr_vld(exc_addr_vld), .exc_vaddr(exc_vaddr),
        .misalign_req(misalign_req), .dbg_req(dbg_req), .dbg_cause_in(dbg_cause_in),
        .cur_level(cur_level), .sw_wr(sw_wr), .sw_wdata(sw_wdata),
        .vec_valid(b_v), .vec_sel(b_sel), .status(b_sw), .saved_pc(b_spc),
        .saved_sw(b_ssw), .dbl_pc(b_dpc), .cause(b_c), .fault_vaddr(b_va),
        .dbg_cause(b_dc));

    // Reference model, one copy per instance: [0] default build, [1] alternate.
    logic [31:0]   m_epc [2][8];
    logic [SW-1:0] m_eps [2][8];
    logic [31:0]   m_dpc [2];
    logic [31:0]   m_va  [2];
    logic [5:0]    m_c   [2];
    logic [5:0]    m_dc  [2];
    logic [SW-1:0] m_sw  [2];
    logic          m_v   [2];
    logic [1:0]    m_sel [2];
    bit            m_has_depc [2];
    bit            m_gate     [2];

    task automatic model_reset(int k);
        for (int i = 0; i < 8; i++) begin
            m_epc[k][i] = '0;
            m_eps[k][i] = '0;
        end
        m_dpc[k] = '0; m_va[k] = '0; m_c[k] = '0; m_dc[k] = '0;
        m_sw[k]  = 5'b1_0_111;
        m_v[k]   = 1'b0; m_sel[k] = 2'd0;
    endtask

    task automatic model_step(int k);
        logic dbg_ok, fault, excm, um;
        dbg_ok = dbg_req && (int'(cur_level) < DBG);
        fault  = exc_req || (misalign_req && m_gate[k]);
        excm   = m_sw[k][4];
        um     = m_sw[k][3];
        if (dbg_ok) begin
            m_epc[k][DBG] = exc_pc;
            m_eps[k][DBG] = m_sw[k];
            m_dc[k]       = dbg_cause_in;
            m_sw[k]       = {1'b1, um, 3'(DBG)};
            m_v[k] = 1'b1; m_sel[k] = 2'd3;
        end else if (fault) begin
            m_c[k] = exc_req ? exc_cause : 6'd9;
            if (!exc_req || exc_addr_vld) m_va[k] = exc_vaddr;
            if (excm) begin
                if (m_has_depc[k]) m_dpc[k] = exc_pc;
                else               m_epc[k][1] = exc_pc;
                m_sel[k] = 2'd2;
            end else begin
                m_epc[k][1] = exc_pc;
                m_sel[k] = um ? 2'd1 : 2'd0;
            end
            m_sw[k][4] = 1'b1;
            m_v[k] = 1'b1;
        end else begin
            m_v[k] = 1'b0; m_sel[k] = 2'd0;
            if (sw_wr) m_sw[k] = sw_wdata;
        end
    endtask

    task automatic chk(string tag, int k, logic [255:0] act, logic [255:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s inst%0d actual=%0h expected=%0h", tag, k, act, exp);
        end
    endtask

    task automatic cmp_inst(int k, logic v, logic [1:0] sel, logic [SW-1:0] sw,
                            logic [MAXL*32-1:0] spc, logic [MAXL*SW-1:0] ssw,
                            logic [31:0] dpc, logic [5:0] c, logic [31:0] va,
                            logic [5:0] dc);
        logic [MAXL*32-1:0] e_spc;
        logic [MAXL*SW-1:0] e_ssw;
        for (int i = 1; i <= MAXL; i++) begin
            e_spc[i*32-1 -: 32] = m_epc[k][i];
            e_ssw[i*SW-1 -: SW] = m_eps[k][i];
        end
        chk("R1 R3 R6 R9 R10 vec_valid", k, 256'(v), 256'(m_v[k]));
        chk("R1 R3 R7 R10 vec_sel", k, 256'(sel), 256'(m_sel[k]));
        chk("R4 R7 R11 R12 status", k, 256'(sw), 256'(m_sw[k]));
        chk("R2 R3 R7 saved_pc", k, 256'(spc), 256'(e_spc));
        chk("R7 saved_sw", k, 256'(ssw), 256'(e_ssw));
        chk("R2 dbl_pc", k, 256'(dpc), 256'(m_dpc[k]));
        chk("R4 R8 R9 cause", k, 256'(c), 256'(m_c[k]));
        chk("R5 fault_vaddr", k, 256'(va), 256'(m_va[k]));
        chk("R7 dbg_cause", k, 256'(dc), 256'(m_dc[k]));
    endtask

    task automatic cmp_both();
        cmp_inst(0, a_v, a_sel, a_sw, a_spc, a_ssw, a_dpc, a_c, a_va, a_dc);
        cmp_inst(1, b_v, b_sel, b_sw, b_spc, b_ssw, b_dpc, b_c, b_va, b_dc);
    endtask

    task automatic apply(logic er, logic [5:0] ec, logic [31:0] pc, logic av,
                         logic [31:0] va, logic mis, logic dr, logic [5:0] dc,
                         logic [LW-1:0] lvl, logic sww, logic [SW-1:0] swd);
        @(negedge clk);
        exc_req = er; exc_cause = ec; exc_pc = pc; exc_addr_vld = av;
        exc_vaddr = va; misalign_req = mis; dbg_req = dr; dbg_cause_in = dc;
        cur_level = lvl; sw_wr = sww; sw_wdata = swd;
        model_step(0);
        model_step(1);
        @(posedge clk);
        #1;
        cmp_both();
    endtask

    initial begin : watchdog
        #(200000 * 10);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin : main
        int unsigned seed;
        m_has_depc[0] = 1'b1; m_gate[0] = 1'b1;
        m_has_depc[1] = 1'b0; m_gate[1] = 1'b0;
        model_reset(0);
        model_reset(1);
        seed = $urandom(32'h5EED_0017);
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R11: reset state of both instances.
        #1 cmp_both();

        // R1 R2: fault right after reset is nested (exception mode set).
        apply(1, 6'd3, 32'h1000_0004, 0, 0, 0, 0, 0, 0, 0, 0);
        // R12: status write on a quiet cycle clears exception mode.
        apply(0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 5'b0_0_000);
        // R3 R5: kernel fault with address.
        apply(1, 6'd12, 32'h2000_0010, 1, 32'hDEAD_BEEF, 0, 0, 0, 0, 0, 0);
        apply(0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 5'b0_1_010);
        // R3 R5: user fault without address keeps old address.
        apply(1, 6'd20, 32'h3000_0020, 0, 32'h1111_1111, 0, 0, 0, 0, 0, 0);
        apply(0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 5'b0_0_001);
        // R8: misalignment alone: cause 9 in default build, ignored in alternate.
        apply(0, 0, 32'h4000_0030, 0, 32'h0000_0123, 1, 0, 0, 0, 0, 0);
        apply(0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 5'b0_0_000);
        // R9: fault request and misalignment together.
        apply(1, 6'd5, 32'h5000_0040, 0, 32'h0000_0456, 1, 0, 0, 0, 0, 0);
        apply(0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 5'b0_1_000);
        // R6: debug at level 6 rejected and ignored.
        apply(0, 0, 32'h6000_0050, 0, 0, 0, 1, 6'd7, 3'd6, 0, 0);
        // R6: rejected debug with a fault in the same cycle.
        apply(1, 6'd8, 32'h6000_0054, 0, 0, 0, 1, 6'd7, 3'd7, 0, 0);
        apply(0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 5'b0_1_010);
        // R7 R9: accepted debug beats a fault.
        apply(1, 6'd2, 32'h7000_0060, 1, 32'h2222_2222, 1, 1, 6'd33, 3'd5, 0, 0);
        // R12: write dropped on an entry cycle.
        apply(1, 6'd4, 32'h8000_0070, 0, 0, 0, 0, 0, 0, 1, 5'b0_0_000);
        // R10: quiet cycle, vec_valid falls.
        apply(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);

        // Constrained random traffic.
        for (int i = 0; i < 600; i++) begin
            logic er, mis, dr, sww;
            er  = ($urandom % 100) < 25;
            mis = ($urandom % 100) < 20;
            dr  = ($urandom % 100) < 15;
            sww = ($urandom % 100) < 40;
            apply(er, 6'($urandom), $urandom, 1'($urandom), $urandom, mis, dr,
                  6'($urandom), 3'($urandom), sww, 5'($urandom));
        end

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule